// File: doc/BRIEF.md
# Gap-Coded Field Write Encoder

This block writes one 80-bit payload into a low-frequency transponder by switching the reader's carrier on and off. Every bit takes the same total time. A bit begins with a short or long interval with the field switched off, and the field is then switched back on for the rest of the bit period. The length of the off interval is the bit's value.

A single start strobe latches a 64-bit data word and a 16-bit checksum, which the caller computes. The block then runs the whole sequence on its own, with no further input:

- It holds the field on to charge the tag.
- It clocks out a fixed header byte and a fixed access byte.
- It sends the data, then the checksum, then a fixed two-byte write trailer.
- It keeps the field on while the tag programs its memory.

A one-microsecond tick input paces every interval, and each duration is a parameter counted in ticks. The `busy` output covers the whole sequence. The `done` output pulses for one clock at the moment the field is finally released.

Top module: `gapcode_writer`

## Requirements
- R1: After reset, and whenever no sequence is running, `field_on`, `busy` and `done` are low.
- R2: A `start` pulse while idle raises `busy` and `field_on` on the next clock. The field then stays on for CHARGE_US ticks before the first bit.
- R3: A bit of value 1 is GAP1_US ticks with `field_on` low, followed by ON1_US ticks with `field_on` high.
- R4: A bit of value 0 is GAP0_US ticks with `field_on` low, followed by ON0_US ticks with `field_on` high.
- R5: The bytes go out in this order: 0xBB, 0xEB, `data_in[7:0]` up to `data_in[63:56]` in ascending byte order, `crc_in[7:0]`, `crc_in[15:8]`, 0x00, 0x03. That makes 112 bits in total.
- R6: Within each byte, bit 0 is sent first and bit 7 last.
- R7: After the on time of the final bit, the field stays on for a further PROG_US ticks. The field and `busy` then drop together.
- R8: `done` is high for exactly one clock, in the clock where `busy` and `field_on` first read low at the end of a sequence.
- R9: `start` has no effect while `busy` is high. `data_in` and `crc_in` are sampled only when a start is accepted, so changing them during a sequence does not alter it.
- R10: Intervals advance only on clocks where `tick` is high. With no tick, `field_on` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a write sequence (used only when idle) |
| tick | input | 1 | One-clock pulse per microsecond |
| data_in | input | DATA_W | Payload, least significant byte sent first |
| crc_in | input | CRC_W | Checksum sent after the payload, low byte first |
| field_on | output | 1 | High enables the reader carrier |
| busy | output | 1 | High from accepted start until the field is released |
| done | output | 1 | One-clock pulse at the end of a sequence |

## Verification
The bench measures every on and off interval of `field_on` in ticks and compares it with a list built from the requirements. This works like a scoreboard. Several payloads are sent, each telling apart a different kind of mistake:
- All zeros and all ones separate the 0-bit timing from the 1-bit timing.
- A mixed byte pattern and a word with only its end bits set expose byte-order and bit-order faults.
- A payload sent straight after a previous `done` shows that sequences can run back to back.

Further runs target the timing and input handling:
- Tick pacing of one, two and three clocks, together with a long pause in ticks mid-frame, shows that only ticks advance the timing.
- Repeated starts with changed data during a frame show that inputs are latched only once per sequence.

// File: rtl/gw_pkg.sv
package gw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CHARGE = 3'd1,
    PH_GAP    = 3'd2,
    PH_ON     = 3'd3,
    PH_PROG   = 3'd4
  } phase_t;

  // fixed frame bytes around the payload
  localparam logic [7:0] HDR_KEY  = 8'hBB;
  localparam logic [7:0] HDR_PASS = 8'hEB;
  localparam logic [7:0] TRL_LO   = 8'h00;
  localparam logic [7:0] TRL_HI   = 8'h03;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gw_tick_timer.sv
module gw_tick_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] len,
  output logic          expire
);

  logic [CW-1:0] cnt;

  assign expire = tick && !clear && (cnt == len - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      if (expire) cnt <= '0;
      else        cnt <= cnt + CW'(1);
    end
  end

  // R10
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> (cnt == $past(cnt)));

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt < len));

endmodule

// File: rtl/gw_bit_shifter.sv
module gw_bit_shifter #(
  parameter int FW = 112
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic          adv,
  output logic          cur_bit,
  output logic          last
);

  localparam int RW = $clog2(FW);

  logic [FW-1:0] sr;
  logic [RW-1:0] rem;

  assign cur_bit = sr[0];
  assign last    = (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      rem <= '0;
    end else if (load) begin
      sr  <= frame_in;
      rem <= RW'(FW - 1);
    end else if (adv) begin
      sr  <= {1'b0, sr[FW-1:1]};
      rem <= rem - RW'(1);
    end
  end

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> !last);

endmodule

// File: rtl/gapcode_writer.sv
module gapcode_writer #(
  parameter int DATA_W    = 64,
  parameter int CRC_W     = 16,
  parameter int GAP1_US   = 1000,
  parameter int ON1_US    = 1000,
  parameter int GAP0_US   = 300,
  parameter int ON0_US    = 1700,
  parameter int CHARGE_US = 50000,
  parameter int PROG_US   = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CRC_W-1:0]  crc_in,
  output logic              field_on,
  output logic              busy,
  output logic              done
);
  import gw_pkg::*;

  localparam int FW   = DATA_W + CRC_W + 32;
  localparam int MAXT = int'(umax(umax(umax(GAP1_US, ON1_US), umax(GAP0_US, ON0_US)),
                                  umax(CHARGE_US, PROG_US)));
  localparam int CW   = $clog2(MAXT + 1);

  phase_t        phase, nxt;
  logic [CW-1:0] len;
  logic          expire, cur_bit, last_bit, adv, load;
  logic [FW-1:0] frame_w;

  // byte order and LSB-first order both follow ascending bit index
  assign frame_w = {TRL_HI, TRL_LO, crc_in, data_in, HDR_PASS, HDR_KEY};

  always_comb begin
    unique case (phase)
      PH_CHARGE: len = CW'(CHARGE_US);
      PH_GAP:    len = cur_bit ? CW'(GAP1_US) : CW'(GAP0_US);
      PH_ON:     len = cur_bit ? CW'(ON1_US)  : CW'(ON0_US);
      PH_PROG:   len = CW'(PROG_US);
      default:   len = CW'(1);
    endcase
  end

  always_comb begin
    nxt  = phase;
    adv  = 1'b0;
    load = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        nxt  = PH_CHARGE;
        load = 1'b1;
      end
      PH_CHARGE: if (expire) nxt = PH_GAP;
      PH_GAP:    if (expire) nxt = PH_ON;
      PH_ON: if (expire) begin
        if (last_bit) nxt = PH_PROG;
        else begin
          nxt = PH_GAP;
          adv = 1'b1;
        end
      end
      PH_PROG:   if (expire) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  gw_tick_timer #(.CW(CW)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (phase == PH_IDLE),
    .tick   (tick),
    .len    (len),
    .expire (expire)
  );

  gw_bit_shifter #(.FW(FW)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .frame_in (frame_w),
    .adv      (adv),
    .cur_bit  (cur_bit),
    .last     (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      field_on <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      phase    <= nxt;
      field_on <= (nxt == PH_CHARGE) || (nxt == PH_ON) || (nxt == PH_PROG);
      busy     <= (nxt != PH_IDLE);
      done     <= (phase == PH_PROG) && expire;
    end
  end

  // R1
  idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !field_on);

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && field_on));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !field_on && $past(busy)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tick) |=> busy);

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> (busy && field_on == $past(field_on)));

endmodule

// File: tb/test_gapcode_writer.sv
module test_gapcode_writer;

  localparam int G1 = 3, O1 = 3, G0 = 1, O0 = 5, CH = 7, PR = 6;

  typedef struct {
    logic  lvl;
    int    len;
    string tag;
  } seg_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        tick = 1'b0;
  logic [63:0] data_in = '0;
  logic [15:0] crc_in = '0;
  logic        field_on, busy, done;

  int   total = 0, bad = 0, done_cnt = 0;
  int   tick_per = 1, div = 0;
  bit   tick_en = 1'b1;
  seg_t exp_q[$];

  always #5 clk = ~clk;

  gapcode_writer #(
    .DATA_W(64), .CRC_W(16), .GAP1_US(G1), .ON1_US(O1), .GAP0_US(G0),
    .ON0_US(O0), .CHARGE_US(CH), .PROG_US(PR)
  ) i_gapcode_writer (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .data_in(data_in),
    .crc_in(crc_in), .field_on(field_on), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // tick generator, driven after the edge
  always @(posedge clk) begin
    #2;
    tick = tick_en && (div == 0);
    div  = (div + 1 >= tick_per) ? 0 : div + 1;
  end

  // monitor: measure intervals in ticks and compare with the scoreboard
  logic cur_lvl = 1'b0;
  bit   seg_busy = 1'b0, prev_done = 1'b0;
  int   seg_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (field_on !== cur_lvl) begin
        if (seg_busy) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected interval", seg_len, 0);
          end else begin
            seg_t e;
            e = exp_q.pop_front();
            chk(cur_lvl === e.lvl && seg_len == e.len, e.tag,
                "interval lvl*1000+ticks", cur_lvl * 1000 + seg_len, e.lvl * 1000 + e.len);
          end
        end
        cur_lvl  = field_on;
        seg_len  = 0;
        seg_busy = busy;
      end
      if (tick) seg_len++;
      if (done) begin
        done_cnt++;
        chk(!busy && !field_on, "R8", "done with busy/field", {busy, field_on}, 0);
        chk(!prev_done, "R8", "done longer than one clock", 1, 0);
      end
      prev_done = done;
    end
  end

  // driver: push the expected intervals, then strobe start
  task automatic send_frame(input logic [63:0] d, input logic [15:0] c);
    logic [111:0] fr;
    seg_t s;
    fr = {8'h03, 8'h00, c, d, 8'hEB, 8'hBB};  // R5 R6
    s.lvl = 1'b1; s.len = CH; s.tag = "R2"; exp_q.push_back(s);
    for (int i = 0; i < 112; i++) begin
      s.lvl = 1'b0; s.len = fr[i] ? G1 : G0;
      s.tag = fr[i] ? "R3 R5 R6 gap" : "R4 R5 R6 gap";
      exp_q.push_back(s);
      s.lvl = 1'b1; s.len = fr[i] ? O1 : O0;
      s.tag = fr[i] ? "R3 on" : "R4 on";
      if (i == 111) begin
        s.len = s.len + PR;
        s.tag = "R7 final on plus programming";
      end
      exp_q.push_back(s);
    end
    @(posedge clk); #2;
    data_in = d; crc_in = c; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_end(input int target, input bit spam);
    int k = 0;
    while (done_cnt < target) begin
      @(posedge clk); #2;
      k++;
      if (spam && busy && (k % 37 == 0)) begin
        start = 1'b1; data_in = ~data_in ^ 64'(k); crc_in = crc_in + 16'h1357;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(exp_q.size() == 0, "R5", "intervals left over", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(!field_on && !busy && !done, "R1", "outputs after reset",
        {field_on, busy, done}, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(!field_on && !busy, "R1", "idle without start", {field_on, busy}, 0);

    // all zeros: 0-bit timing only in payload
    tick_per = 1;
    send_frame(64'h0, 16'h0);
    wait_end(1, 1'b0);

    // all ones, slower ticks
    tick_per = 2;
    send_frame(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF);
    wait_end(2, 1'b0);

    // mixed pattern with starts and data changes during the frame
    tick_per = 1;
    send_frame(64'h0123_4567_89AB_CDEF, 16'hA55A);
    wait_end(3, 1'b1);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(!busy && !field_on, "R9", "no frame after ignored starts", {busy, field_on}, 0);

    // end bits only, tick every third clock, pause ticks mid-frame
    tick_per = 3;
    send_frame(64'h8000_0000_0000_0001, 16'h8001);
    repeat (400) @(posedge clk);
    #2 tick_en = 1'b0;
    begin
      logic f0;
      @(negedge clk);
      f0 = field_on;
      repeat (25) @(negedge clk);
      chk(field_on === f0 && busy, "R10", "field moved without ticks", field_on, f0);
    end
    @(posedge clk); #2 tick_en = 1'b1;
    wait_end(4, 1'b0);

    // back-to-back frame right after done
    tick_per = 1;
    send_frame(64'hFEDC_BA98_7654_3210, 16'h0F1E);
    wait_end(5, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(done_cnt == 5, "R8", "done pulse count", done_cnt, 5);
    chk(!busy && !field_on && !done, "R1", "idle after last frame",
        {busy, field_on, done}, 0);
    finish_run();
  end

endmodule